// File: doc/BRIEF.md
# External Bus Strobe Stretch Controller

This block sequences the control strobes of one external bus cycle. A requester offers a 22-bit address and a write flag on a valid/ready request port. Once the request is accepted, the block pulls the active-low address strobe low, then one data strobe, then releases both. It then reports completion with a one-cycle done pulse. Each strobe can be lengthened by a number of extra clock cycles taken from two configuration registers. The counts differ between the upper and lower halves of the address space, and the top address bit selects the half.

The block holds two configuration registers. The wait register holds a data-strobe stretch for each half and a watchdog-enable bit that is brought out as a plain pin. The strobe register holds an address-strobe stretch, which only upper-half cycles use, and a steering bit that moves lower-half data strobes onto a second strobe line. The strobe register is protected against writes made while the interrupt-service input is high. Every stretch value is counted in cycles of `clk`.

Back-pressure rule: `req_ready` is high only while no cycle is in progress. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While the block is busy, the requester must hold `req_valid` with its address and write flag stable until `req_ready` returns. Configuration written during a cycle only affects the next accepted request.

Top module: `extbus_strobe_ctrl`

## Requirements
- R1: During and after reset, with no request, `as_n`, `ds_n`, `ds2_n` and `rw_n` are high, `busy` and `done` are low, and `req_ready` is high.
- R2: Address bit 21 selects the region: 1 is the upper half and 0 is the lower half.
- R3: `as_n` is low for 1 + A cycles on an upper-half cycle and for exactly 1 cycle on a lower-half cycle. A is the strobe register bits [1:0], which reset to 3.
- R4: On an upper-half cycle, `ds_n` is low for 1 + U cycles and `ds2_n` stays high. U is the wait register bits [5:3], which reset to 7.
- R5: On a lower-half cycle, one data strobe is low for 1 + L cycles, where L is the wait register bits [2:0] (reset 7). The strobe is `ds2_n` when the strobe register bit 2 is 1 (reset 0), otherwise `ds_n`.
- R6: The wait register resets so that `wdg_en` is 1 and both data stretches are 7. A write with `cfg_sel`=0 loads bit 6 to `wdg_en`, bits [5:3] to U and bits [2:0] to L.
- R7: A write with `cfg_sel`=1 while `in_isr` is high leaves the strobe register unchanged. Writes to the wait register still take effect.
- R8: `done` is high for exactly one cycle, directly after the data strobe rises, with all strobes high. `req_ready` is high in the following cycle.
- R9: From acceptance until after `done`, `busy` is high and `req_ready` is low, and a waiting request is not taken.
- R10: Stretch counts and steering are captured at acceptance. A register write during a cycle does not alter that cycle.
- R11: `as_n` falls in the cycle after acceptance. The data strobe falls in the cycle after `as_n` rises. At most one strobe is low at any time.
- R12: `rw_n` is low throughout a cycle whose request had `req_write`=1 and high throughout a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all stretch counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 22 | Access address; bit 21 selects the region |
| req_write | input | 1 | 1 for a write cycle |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Primary data strobe, active low |
| ds2_n | output | 1 | Secondary data strobe, active low |
| rw_n | output | 1 | Low during write cycles |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the wait register, 1 the strobe register |
| cfg_wdata | input | 8 | Configuration write data |
| in_isr | input | 1 | Interrupt service active; blocks strobe-register writes |
| wdg_en | output | 1 | Watchdog-enable bit of the wait register |

## Verification
After acceptance on edge 0, `as_n` is low from edge 1 for 1 + A cycles. The data strobe follows straight after for 1 + U or 1 + L cycles. `done` comes on the next edge, and `req_ready` returns one edge later. The bench does not predict fixed edges. Its monitor samples every output on the falling clock edge and counts how many samples each strobe spends low. When it sees `done`, it compares those counts with the entry the driver queued at acceptance, and that entry was computed from a shadow copy of the registers. The single-cycle `done`, ready on the following sample, and busy right after acceptance are checked on the samples where they are due.

// File: rtl/extbus_strobe_pkg.sv
package extbus_strobe_pkg;
  localparam int AS_STR_W = 2;
  localparam int DS_STR_W = 3;
  localparam int CNT_W    = (AS_STR_W > DS_STR_W) ? AS_STR_W : DS_STR_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } bus_state_e;

  // Per-cycle settings captured when a request is accepted
  typedef struct packed {
    logic [AS_STR_W-1:0] as_str;
    logic [DS_STR_W-1:0] ds_str;
    logic                use_ds2;
    logic                wr;
  } cycle_snap_t;
endpackage

// File: rtl/extbus_cfg_regs.sv
module extbus_cfg_regs
  import extbus_strobe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                sel,
  input  logic [7:0]          wdata,
  input  logic                in_isr,
  output logic [AS_STR_W-1:0] as_str,
  output logic                ds2_en,
  output logic [DS_STR_W-1:0] upper_ds,
  output logic [DS_STR_W-1:0] lower_ds,
  output logic                wdg_en
);
  localparam int LO_LSB = 0;
  localparam int UP_LSB = DS_STR_W;
  localparam int WDG_BIT = 2 * DS_STR_W;
  localparam int STEER_BIT = AS_STR_W;

  logic wait_we, strobe_we;
  assign wait_we   = wr_en && !sel;
  assign strobe_we = wr_en && sel && !in_isr;

  // Wait register: data-strobe stretches and watchdog enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_ds <= '1;
      lower_ds <= '1;
      wdg_en   <= 1'b1;
    end else if (wait_we) begin
      upper_ds <= wdata[UP_LSB +: DS_STR_W];
      lower_ds <= wdata[LO_LSB +: DS_STR_W];
      wdg_en   <= wdata[WDG_BIT];
    end
  end

  // Strobe register: address-strobe stretch and lower-half steering
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_str <= '1;
      ds2_en <= 1'b0;
    end else if (strobe_we) begin
      as_str <= wdata[AS_STR_W-1:0];
      ds2_en <= wdata[STEER_BIT];
    end
  end
endmodule

// File: rtl/extbus_cycle_select.sv
module extbus_cycle_select
  import extbus_strobe_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                write,
  input  logic [AS_STR_W-1:0] as_str,
  input  logic                ds2_en,
  input  logic [DS_STR_W-1:0] upper_ds,
  input  logic [DS_STR_W-1:0] lower_ds,
  output cycle_snap_t         snap
);
  localparam int REGION_BIT = ADDR_W - 1;

  logic upper;
  assign upper = addr[REGION_BIT];

  always_comb begin
    snap.as_str  = upper ? as_str : '0;
    snap.ds_str  = upper ? upper_ds : lower_ds;
    snap.use_ds2 = !upper && ds2_en;
    snap.wr      = write;
  end
endmodule

// File: rtl/extbus_strobe_seq.sv
module extbus_strobe_seq
  import extbus_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  cycle_snap_t snap,
  output logic        as_n,
  output logic        ds_n,
  output logic        ds2_n,
  output logic        rw_n,
  output logic        done,
  output logic        busy
);
  bus_state_e       state;
  logic [CNT_W-1:0] cnt;
  cycle_snap_t      cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      cur   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cur   <= snap;
          cnt   <= CNT_W'(snap.as_str);
          state <= ST_ADDR;
        end
        ST_ADDR: if (cnt == '0) begin
          cnt   <= CNT_W'(cur.ds_str);
          state <= ST_DATA;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_DATA: if (cnt == '0) state <= ST_DONE;
                 else cnt <= cnt - 1'b1;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign as_n  = !(state == ST_ADDR);
  assign ds_n  = !(state == ST_DATA && !cur.use_ds2);
  assign ds2_n = !(state == ST_DATA && cur.use_ds2);
  assign rw_n  = !(state != ST_IDLE && cur.wr);
  assign done  = (state == ST_DONE);
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/extbus_strobe_ctrl.sv
module extbus_strobe_ctrl
  import extbus_strobe_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              busy,
  output logic              done,
  output logic              as_n,
  output logic              ds_n,
  output logic              ds2_n,
  output logic              rw_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              in_isr,
  output logic              wdg_en
);
  logic [AS_STR_W-1:0] as_str;
  logic                ds2_en;
  logic [DS_STR_W-1:0] upper_ds, lower_ds;
  cycle_snap_t         snap;
  logic                start;

  extbus_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sel(cfg_sel),
    .wdata(cfg_wdata), .in_isr(in_isr), .as_str(as_str), .ds2_en(ds2_en),
    .upper_ds(upper_ds), .lower_ds(lower_ds), .wdg_en(wdg_en)
  );

  extbus_cycle_select #(.ADDR_W(ADDR_W)) u_sel (
    .addr(req_addr), .write(req_write), .as_str(as_str), .ds2_en(ds2_en),
    .upper_ds(upper_ds), .lower_ds(lower_ds), .snap(snap)
  );

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  extbus_strobe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .snap(snap),
    .as_n(as_n), .ds_n(ds_n), .ds2_n(ds2_n), .rw_n(rw_n),
    .done(done), .busy(busy)
  );
endmodule

// File: rtl/extbus_strobe_chk.sv
module extbus_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic as_n,
  input logic ds_n,
  input logic ds2_n
);
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~as_n, ~ds_n, ~ds2_n}));

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !as_n));

  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && ds_n && ds2_n));

  a_r8_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!ds_n || !ds2_n));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  a_r11_data_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) || $fell(ds2_n)) |-> $past(!as_n));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (as_n && ds_n && ds2_n && !done));
endmodule

bind extbus_strobe_ctrl extbus_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .as_n(as_n), .ds_n(ds_n), .ds2_n(ds2_n)
);

// File: tb/extbus_strobe_ctrl_bench.sv
module extbus_strobe_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        busy, done, as_n, ds_n, ds2_n, rw_n, wdg_en;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_isr = 1'b0;

  always #4 clk = ~clk;

  extbus_strobe_ctrl u_extbus_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .busy(busy), .done(done),
    .as_n(as_n), .ds_n(ds_n), .ds2_n(ds2_n), .rw_n(rw_n),
    .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_isr(in_isr), .wdg_en(wdg_en)
  );

  typedef struct {
    int as_len; int ds_len; int ds2_len; bit wr; string tag;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // shadow of the configuration registers
  int m_as = 3, m_uds = 7, m_lds = 7;
  bit m_ds2 = 0, m_wdg = 1;

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic cfg_write(bit sel, logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    if (!sel) begin
      m_uds = d[5:3]; m_lds = d[2:0]; m_wdg = d[6];
    end else if (!in_isr) begin
      m_as = d[1:0]; m_ds2 = d[2];
    end
  endtask

  // Driver: holds the request until accepted, queues the expected strobe widths
  task automatic issue(logic [21:0] a, bit wr, string tag);
    exp_t e;
    bit up;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    while (!req_ready) @(negedge clk);
    up = a[21];
    e.as_len = 1 + (up ? m_as : 0);
    e.ds_len = 0; e.ds2_len = 0;
    if (up) e.ds_len = 1 + m_uds;
    else if (m_ds2) e.ds2_len = 1 + m_lds;
    else e.ds_len = 1 + m_lds;
    e.wr = wr; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: counts strobe-low samples and compares on done
  int c_as = 0, c_ds = 0, c_ds2 = 0;
  bit saw_wr = 0, saw_rd = 0, prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        check(done == 1'b0, "R8 done width", done, 0);
        check(req_ready == 1'b1, "R8 ready after done", req_ready, 1);
      end
      if (!as_n) c_as++;
      if (!ds_n) c_ds++;
      if (!ds2_n) c_ds2++;
      if (busy && !done) begin
        if (!rw_n) saw_wr = 1; else saw_rd = 1;
      end
      if (done) begin
        check(as_n && ds_n && ds2_n, "R8 strobes high at done",
              {as_n, ds_n, ds2_n}, 7);
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected cycle", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(c_as == e.as_len, {"R3 as width ", e.tag}, c_as, e.as_len);
          check(c_ds == e.ds_len, {"R4/R5 ds width ", e.tag}, c_ds, e.ds_len);
          check(c_ds2 == e.ds2_len, {"R5 ds2 width ", e.tag}, c_ds2, e.ds2_len);
          check(saw_wr == e.wr && saw_rd == !e.wr, {"R12 rw_n ", e.tag},
                saw_wr, e.wr);
        end
        c_as = 0; c_ds = 0; c_ds2 = 0; saw_wr = 0; saw_rd = 0;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(as_n && ds_n && ds2_n && rw_n, "R1 strobes high in reset",
          {as_n, ds_n, ds2_n, rw_n}, 15);
    check(!busy && !done, "R1 idle in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(wdg_en == 1'b1, "R6 wdg_en reset", wdg_en, 1);

    // R2/R3/R4/R6 reset stretches, upper and lower region
    issue(22'h200000, 1'b0, "R6 upper reset");
    @(negedge clk);
    check(busy && !req_ready, "R9 busy after accept", {busy, req_ready}, 2);
    issue(22'h1FFFFF, 1'b1, "R2 lower reset write");   // held until ready (R9)

    // R6 wait-register write
    cfg_write(1'b0, 8'h00);
    @(negedge clk);
    check(wdg_en == 1'b0, "R6 wdg_en cleared", wdg_en, 0);
    issue(22'h3ABCDE, 1'b1, "R4 upper zero");
    issue(22'h012345, 1'b0, "R5 lower zero");

    // R5 steering to ds2, R3 as stretch
    cfg_write(1'b1, 8'h05);   // as=1, steer=1
    cfg_write(1'b0, 8'h53);   // wdg=1, upper=2, lower=3
    check(1'b1, "R6 write", 0, 0);
    issue(22'h200001, 1'b0, "R3 upper as1");
    issue(22'h000001, 1'b0, "R5 lower ds2");

    // R7 strobe register protected during interrupt service
    in_isr = 1'b1;
    cfg_write(1'b1, 8'h02);   // ignored
    cfg_write(1'b0, 8'h0C);   // upper=1, lower=4, still applies
    in_isr = 1'b0;
    issue(22'h2FFFFF, 1'b0, "R7 as kept");
    issue(22'h0FFFFF, 1'b1, "R7 steer kept");

    // R10 write during a cycle affects only the next one
    issue(22'h200000, 1'b0, "R10 old cfg");
    cfg_write(1'b1, 8'h03);   // as=3, steer=0
    cfg_write(1'b0, 8'h3F);
    issue(22'h000000, 1'b0, "R10 new cfg lower");
    issue(22'h200000, 1'b1, "R10 new cfg upper");

    // sweep of stretch combinations
    for (int u = 0; u < 8; u += 3) begin
      for (int l = 0; l < 8; l += 5) begin
        cfg_write(1'b0, 8'((u << 3) | l));
        cfg_write(1'b1, 8'(((u & 1) << 2) | (l & 3)));
        issue(22'h3C0000, u[0], "R4 sweep upper");
        issue(22'h040000, l[0], "R5 sweep lower");
      end
    end

    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all cycles completed", exp_q.size(), 0);
    report();
  end
endmodule